// File: doc/BRIEF.md
# Fan Tachometer Speed Monitor

This block turns the pulse train from a fan tachometer into an 8-bit period count and raises an interrupt when the count shows that the fan is turning too slowly. The raw tach pin is asynchronous. It passes through a synchronizer and a level filter, so slow, noisy edges do not produce false pulses. The fan gives two tach pulses per revolution. The block therefore times one full revolution, from one counted rising edge to the rising edge two pulses later. It counts 20 kHz reference ticks, thinned by a selectable prescaler, so the captured value equals 1,200,000 / (RPM × divisor).

A slow fan produces a large count. The alarm condition is a count that is at or above a host-programmed threshold. If the fan stops completely, the running count saturates at 0xFF. The result is then published at once, so a stalled fan is reported without waiting for an edge that never comes. The host acknowledges an interrupt by writing 1 to a clear strobe. The next measurement also re-evaluates the interrupt.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, count_out is 0x00, irq_n is 1 and irq_src is 0x00.
- R2: A tach level change that lasts fewer than 4 system clocks after the two-flop synchronizer is ignored and does not alter any measurement.
- R3: div_sel codes 0, 1, 2 and 3 select divisors N = 1, 2, 4 and 8. Only every Nth tick_20k strobe is counted.
- R4: After mon_en rises, the first filtered rising edge only starts a revolution. From then on, every second filtered rising edge latches the count of prescaled ticks seen since the previous start into count_out, and restarts the count.
- R5: The running count saturates at 0xFF. When it reaches 0xFF, count_out becomes 0xFF without waiting for a tach edge.
- R6: At each capture, if irq_en is 1 and count_out ≥ thresh, the interrupt flag is set. While the flag is set, irq_n is 0 and irq_src is 0x38. While it is clear, irq_n is 1 and irq_src is 0x00.
- R7: A one-cycle pulse on irq_clr clears a pending interrupt on the next clock edge. A capture that sets the flag in the same cycle takes priority over the clear.
- R8: A capture whose count is below thresh clears a pending interrupt.
- R9: While mon_en is 0, no measurement takes place, count_out holds its last value and irq_n stays 1.
- R10: While irq_en is 0, irq_n stays 1 regardless of count and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_20k | input | 1 | One-cycle strobe at the 20 kHz reference rate |
| tach_in | input | 1 | Raw asynchronous fan tachometer input |
| mon_en | input | 1 | Monitor enable (control register bit 7) |
| irq_en | input | 1 | Interrupt enable (control register bit 6) |
| div_sel | input | 2 | Divisor select (control register bits 1:0) |
| thresh | input | 8 | Alarm threshold compared against the count |
| irq_clr | input | 1 | Write-1 clear strobe for the interrupt |
| count_out | output | 8 | Last captured revolution count |
| irq_n | output | 1 | Active-low interrupt |
| irq_src | output | 8 | Interrupt source code, 0x38 while pending |

## Verification
A tach edge reaches the counter about seven clocks after the pin changes: two synchronizer flops, four filter clocks and the edge-detect register. count_out changes on the clock after that. irq_n and irq_src follow one clock later, because the comparison registers the result that has just been captured. The bench always waits twelve clocks after driving the last tach period before it samples count_out and irq_n, which keeps it clear of that eight-to-nine-clock path. For a write-1 clear, the bench checks irq_n at the first falling clock after the strobe's edge. For a stall, it waits more than 255 × 8 reference ticks before checking. Because tach_in is driven on whole clock periods and tick_20k arrives every second clock, a revolution of 4H clocks contains exactly 2H ticks. The bench can therefore predict each count exactly as min(255, 2H/N).

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int CNT_W = 8;
  localparam int SRC_W = 8;
  localparam logic [SRC_W-1:0] IRQ_SRC_CODE = 8'h38;
  localparam int DIV_SEL_W = 2;
endpackage

// File: rtl/tach_conditioner.sv
// Synchronizes the raw tach pin, rejects short level changes and emits
// a single-cycle pulse on each accepted rising edge.
module tach_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tach_raw,
  output logic rise
);
  localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [FW-1:0] RUN_LAST = FW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;
  logic                   filt_q;
  logic [FW-1:0]          run_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], tach_raw};
  end

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
      rise   <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (sync_out == filt_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        filt_q <= sync_out;
        run_q  <= '0;
        rise   <= sync_out;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R2: the filtered level only moves after the synchronized input disagreed with it
  a_r2_filter_change: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> ($past(sync_out) != $past(filt_q)));

  // R2: an accepted edge is a single-cycle pulse
  a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tach_prescaler.sv
// Passes one out of every 2**div_sel reference ticks; phase restarts with
// each revolution so the window holds an exact number of passes.
module tach_prescaler #(
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 restart,
  input  logic                 tick,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 pass
);
  localparam int MAX_SHIFT = (1 << DIV_SEL_W) - 1;
  localparam int PW        = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [PW-1:0] acc_q;
  logic [PW-1:0] base;
  logic [PW-1:0] limit;

  always_comb begin
    limit = {PW{1'b1}} >> (MAX_SHIFT - int'(div_sel));
    base  = restart ? '0 : acc_q;
    pass  = en && tick && (base == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  acc_q <= '0;
    else if (tick)   acc_q <= (base == limit) ? '0 : base + 1'b1;
    else             acc_q <= base;
  end

  // R3: a counted tick always comes from a reference strobe
  a_r3_pass_on_tick: assert property (@(posedge clk) disable iff (rst)
    pass |-> (tick && en));

  // R3: prescaler phase is zero right after a restart without a tick
  a_r3_phase_reset: assert property (@(posedge clk) disable iff (rst)
    (en && restart && !tick) |=> (acc_q == '0));
endmodule

// File: rtl/tach_period_counter.sv
// Counts prescaled ticks over one revolution (two tach pulses), captures
// the count, and publishes saturation at once for a stalled fan.
module tach_period_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rise,
  input  logic             pass,
  output logic             restart,
  output logic [CNT_W-1:0] result,
  output logic             eval
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - 1'b1;

  logic             started_q;
  logic             half_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base_cnt;
  logic             capture;
  logic             stall;

  always_comb begin
    restart  = en && rise && (!started_q || half_q);
    capture  = en && rise && started_q && half_q;
    base_cnt = restart ? '0 : cnt_q;
    stall    = en && pass && (base_cnt == CNT_NEAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      half_q    <= 1'b0;
      cnt_q     <= '0;
      result    <= '0;
      eval      <= 1'b0;
    end else if (!en) begin
      started_q <= 1'b0;
      half_q    <= 1'b0;
      cnt_q     <= '0;
      eval      <= 1'b0;
    end else begin
      eval <= 1'b0;
      if (rise) begin
        if (!started_q) begin
          started_q <= 1'b1;
          half_q    <= 1'b0;
        end else begin
          half_q <= ~half_q;
        end
      end
      if (pass && (base_cnt != CNT_MAX)) cnt_q <= base_cnt + 1'b1;
      else                               cnt_q <= base_cnt;
      if (capture) begin
        result <= cnt_q;
        eval   <= 1'b1;
      end else if (stall) begin
        result <= CNT_MAX;
        eval   <= 1'b1;
      end
    end
  end

  // R5: a saturated count stays saturated until the next restart
  a_r5_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !restart && (cnt_q == CNT_MAX)) |=> (cnt_q == CNT_MAX));

  // R9: a disabled monitor clears its running state and makes no capture
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((cnt_q == '0) && !eval));

  // R9: the published count only moves on an evaluation
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !eval |-> $stable(result));
endmodule

// File: rtl/tach_alarm.sv
// Threshold comparison, write-1 clear and registered interrupt outputs.
module tach_alarm #(
  parameter int                CNT_W    = 8,
  parameter int                SRC_W    = 8,
  parameter logic [SRC_W-1:0]  SRC_CODE = 8'h38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mon_en,
  input  logic             irq_en,
  input  logic             eval,
  input  logic [CNT_W-1:0] result,
  input  logic [CNT_W-1:0] thresh,
  input  logic             irq_clr,
  output logic             irq_n,
  output logic [SRC_W-1:0] irq_src
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    if (!mon_en || !irq_en) flag_d = 1'b0;
    else if (eval)          flag_d = (result >= thresh);
    else if (irq_clr)       flag_d = 1'b0;
    else                    flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      irq_n   <= 1'b1;
      irq_src <= '0;
    end else begin
      flag_q  <= flag_d;
      irq_n   <= ~flag_d;
      irq_src <= flag_d ? SRC_CODE : '0;
    end
  end

  // R6: source code reported while pending
  a_r6_src_pending: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (irq_src == SRC_CODE));

  // R6: source code idle while not pending
  a_r6_src_idle: assert property (@(posedge clk) disable iff (rst)
    irq_n |-> (irq_src == '0));

  // R7: clear strobe without a capture drops the interrupt
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !eval) |=> irq_n);

  // R9: monitor off keeps the interrupt inactive
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> irq_n);

  // R10: interrupt enable off keeps the interrupt inactive
  a_r10_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> irq_n);
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
  import fan_tach_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_20k,
  input  logic                 tach_in,
  input  logic                 mon_en,
  input  logic                 irq_en,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0]     thresh,
  input  logic                 irq_clr,
  output logic [CNT_W-1:0]     count_out,
  output logic                 irq_n,
  output logic [SRC_W-1:0]     irq_src
);
  logic rise;
  logic pass;
  logic restart;
  logic eval;

  tach_conditioner #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_cond (
    .clk     (clk),
    .rst     (rst),
    .tach_raw(tach_in),
    .rise    (rise)
  );

  tach_prescaler #(
    .DIV_SEL_W(DIV_SEL_W)
  ) u_presc (
    .clk    (clk),
    .rst    (rst),
    .en     (mon_en),
    .restart(restart),
    .tick   (tick_20k),
    .div_sel(div_sel),
    .pass   (pass)
  );

  tach_period_counter #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk    (clk),
    .rst    (rst),
    .en     (mon_en),
    .rise   (rise),
    .pass   (pass),
    .restart(restart),
    .result (count_out),
    .eval   (eval)
  );

  tach_alarm #(
    .CNT_W   (CNT_W),
    .SRC_W   (SRC_W),
    .SRC_CODE(IRQ_SRC_CODE)
  ) u_alarm (
    .clk    (clk),
    .rst    (rst),
    .mon_en (mon_en),
    .irq_en (irq_en),
    .eval   (eval),
    .result (count_out),
    .thresh (thresh),
    .irq_clr(irq_clr),
    .irq_n  (irq_n),
    .irq_src(irq_src)
  );

  // R4: a capture only happens while the monitor is enabled
  a_r4_eval_enabled: assert property (@(posedge clk) disable iff (rst)
    eval |-> $past(mon_en));
endmodule

// File: tb/fan_tach_monitor_tb.sv
module fan_tach_monitor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_20k = 1'b0;
  logic       tach_in = 1'b0;
  logic       mon_en = 1'b0;
  logic       irq_en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [7:0] thresh = 8'd0;
  logic       irq_clr = 1'b0;
  logic [7:0] count_out;
  logic       irq_n;
  logic [7:0] irq_src;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  fan_tach_monitor u_dut (
    .clk(clk), .rst(rst), .tick_20k(tick_20k), .tach_in(tach_in),
    .mon_en(mon_en), .irq_en(irq_en), .div_sel(div_sel), .thresh(thresh),
    .irq_clr(irq_clr), .count_out(count_out), .irq_n(irq_n), .irq_src(irq_src)
  );

  always #5 clk = ~clk;

  // reference strobe on every second clock
  initial begin
    forever begin
      @(negedge clk);
      tick_20k = ~tick_20k;
    end
  end

  function automatic int exp_count(int ticks, int dsel);
    int c;
    c = ticks >> dsel;
    return (c > 255) ? 255 : c;
  endfunction

  task automatic check(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic check_irq(string req, bit exp_pending);
    check(req, int'(irq_n), exp_pending ? 0 : 1);
    check(req, int'(irq_src), exp_pending ? 8'h38 : 8'h00);
  endtask

  task automatic tach_period(int h);
    tach_in = 1'b0;
    repeat (h) @(negedge clk);
    tach_in = 1'b1;
    repeat (h) @(negedge clk);
  endtask

  // period with 3-clock glitches in both the low and the high phase
  task automatic glitch_period(int h);
    tach_in = 1'b0;
    repeat (h / 2) @(negedge clk);
    tach_in = 1'b1;
    repeat (3) @(negedge clk);
    tach_in = 1'b0;
    repeat (h - h / 2 - 3) @(negedge clk);
    tach_in = 1'b1;
    repeat (h / 2) @(negedge clk);
    tach_in = 1'b0;
    repeat (3) @(negedge clk);
    tach_in = 1'b1;
    repeat (h - h / 2 - 3) @(negedge clk);
  endtask

  // restart the monitor, run five rising edges (start + two captures)
  task automatic run_trial(int h, int dsel, int thr, bit ien, bit glitchy);
    mon_en = 1'b0;
    tach_in = 1'b0;
    repeat (10) @(negedge clk);
    div_sel = 2'(dsel);
    thresh  = 8'(thr);
    irq_en  = ien;
    mon_en  = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (glitchy) glitch_period(h);
      else         tach_period(h);
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int e;
    int h;
    int d;
    int t;
    bit ie;
    void'($urandom(32'h5eed_c0de));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(count_out), 0);
    check_irq("R1", 1'b0);

    // R3/R4/R6: exact boundary count == threshold
    run_trial(100, 1, 100, 1'b1, 1'b0);
    check("R3", int'(count_out), exp_count(200, 1));
    check_irq("R6", 1'b1);

    // R6: threshold one above count -> no interrupt
    run_trial(100, 1, 101, 1'b1, 1'b0);
    check("R4", int'(count_out), 100);
    check_irq("R6", 1'b0);

    // R2: glitches do not change the count
    run_trial(60, 0, 255, 1'b0, 1'b1);
    check("R2", int'(count_out), exp_count(120, 0));

    // R10: masked interrupt even with threshold 0
    run_trial(40, 2, 0, 1'b0, 1'b0);
    check("R10", int'(count_out), exp_count(80, 2));
    check_irq("R10", 1'b0);

    // R5: saturation within a revolution at divisor 1
    run_trial(200, 0, 250, 1'b1, 1'b0);
    check("R5", int'(count_out), 255);
    check_irq("R6", 1'b1);

    // R5: stalled fan, divisor 8
    mon_en = 1'b0;
    repeat (10) @(negedge clk);
    div_sel = 2'd3;
    thresh  = 8'd200;
    irq_en  = 1'b1;
    mon_en  = 1'b1;
    tach_period(20);
    repeat (4200) @(negedge clk);
    check("R5", int'(count_out), 255);
    check_irq("R5", 1'b1);

    // R7: write-1 clear
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check_irq("R7", 1'b0);
    repeat (5) @(negedge clk);
    check_irq("R7", 1'b0);

    // R8: next capture below threshold clears a pending interrupt
    run_trial(100, 0, 150, 1'b1, 1'b0);
    check("R4", int'(count_out), 200);
    check_irq("R8", 1'b1);
    thresh = 8'd250;
    tach_period(100);
    tach_period(100);
    repeat (12) @(negedge clk);
    // window spans the 12-clock pause: (4*100 + 12)/2 ticks
    check("R8", int'(count_out), 206);
    check_irq("R8", 1'b0);

    // R9: disabled monitor holds count and keeps interrupt off
    thresh = 8'd0;
    mon_en = 1'b0;
    for (int i = 0; i < 5; i++) tach_period(40);
    repeat (12) @(negedge clk);
    check("R9", int'(count_out), 206);
    check_irq("R9", 1'b0);

    // random trials
    for (int k = 0; k < 24; k++) begin
      h  = 8 + 2 * int'($urandom % 146);
      d  = int'($urandom % 4);
      ie = 1'($urandom % 2);
      e  = exp_count(2 * h, d);
      case ($urandom % 3)
        0: t = e;
        1: t = (e < 255) ? e + 1 : e;
        default: t = int'($urandom % 256);
      endcase
      run_trial(h, d, t, ie, 1'b0);
      check("R3", int'(count_out), e);
      check_irq("R6", ie && (e >= t));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule